// File: doc/BRIEF.md
# Multi-Context Register Frame Unit

This block holds the architectural register state of four resident threads. Each thread owns a task frame: a bank of local general registers, a saved program-counter pair (current and next PC) and a 32-bit status word. A frame pointer picks the frame in use. Every local register access, every status access and every PC-chain save goes to the frame it selects. A small bank of shared registers stays reachable from any frame. A trap handler that runs without moving the pointer therefore sees all the registers of the thread that trapped.

Software moves the pointer with four operations: step up, step down, load a value, or leave it alone. The current pointer is always visible, so it can be copied into a register. The status word of the active frame is read and written through its own port pair, which lets the pipeline move it to and from general registers. The memory controller forces a thread change with a switch request. The unit stops instruction issue and waits until the pipeline reports that it is empty. It then stores the outgoing PC chain into the outgoing frame, moves the pointer to the requested frame, and presents that frame's saved PC chain for fetch.

Top module: `ctxRegFile`

## Requirements
- R1: After reset the frame pointer is 0, `busy`, `haltIssue` and `resumeValid` are low, and every register, saved PC, saved next PC and status word reads 0.
- R2: Register indices 0 to 7 address eight shared registers. A value written there reads back the same from every frame.
- R3: Indices 8 to 31 address the local registers of the frame the pointer selects. A write in one frame is not visible in another, and it is still present when the pointer returns, including after a forced switch.
- R4: `fpOp` is encoded as 0 = hold, 1 = step up, 2 = step down, 3 = load. The pointer changes on the next clock edge. Stepping up from 3 gives 0 and stepping down from 0 gives 3. Hold leaves the pointer unchanged.
- R5: A load operation makes `curFp` equal to `fpWrData` on the next edge.
- R6: Each frame has its own 32-bit status word. `statusWrEn` writes the active frame's word, and `statusRdData` always shows the active frame's word.
- R7: A switch request taken while idle raises `busy` and `haltIssue` on the next edge. While `pipeEmpty` is low, the unit stays in the drain step and the pointer does not move.
- R8: Once drained, the unit stores `pcIn`/`npcIn` into the outgoing frame and moves the pointer to the requested frame. For one cycle it then raises `resumeValid`, with `resumePc`/`resumeNpc` equal to that frame's saved PC chain.
- R9: While `busy` is high, pointer operations on `fpOp` are ignored.
- R10: A switch request that arrives while a switch is under way is held. It starts right after the current switch ends, without a new request.
- R11: When the pipeline is already empty, `busy` stays high for exactly four cycles: drain, save, pointer change and PC presentation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdIdxA | input | 5 | Read index, port A |
| rdDataA | output | 32 | Read data, port A (combinational) |
| rdIdxB | input | 5 | Read index, port B |
| rdDataB | output | 32 | Read data, port B (combinational) |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 5 | Register write index |
| wrData | input | 32 | Register write data |
| fpOp | input | 2 | Pointer operation: 0 hold, 1 up, 2 down, 3 load |
| fpWrData | input | 2 | Value used by the load operation |
| curFp | output | 2 | Current frame pointer |
| statusWrEn | input | 1 | Write the active frame's status word |
| statusWrData | input | 32 | Status write data |
| statusRdData | output | 32 | Active frame's status word |
| pcIn | input | 32 | PC of the outgoing thread, saved during a switch |
| npcIn | input | 32 | Next PC of the outgoing thread |
| switchReq | input | 1 | Forced context switch request |
| switchTarget | input | 2 | Frame to switch to |
| pipeEmpty | input | 1 | Pipeline has drained |
| busy | output | 1 | Switch in progress |
| haltIssue | output | 1 | Stop issuing instructions, waiting for the drain |
| resumeValid | output | 1 | Saved PC chain of the new frame is presented |
| resumePc | output | 32 | Saved PC of the active frame |
| resumeNpc | output | 32 | Saved next PC of the active frame |

## Verification
The assertions check the pointer arithmetic on every cycle: step up, step down, load and hold while idle. They also check that the pointer stays still while the drain step waits, that a request taken while idle raises busy, and that the PC-chain presentation lasts a single cycle inside the busy window. Only the bench scenarios can show which values reach the ports. That covers shared registers seen from several frames, local registers kept across a forced switch, and per-frame status words. It also covers the saved PC chain that reappears when the unit returns to a frame, the exact four-cycle busy window, and the queued second request.

// File: rtl/ctxFramePkg.sv
package ctxFramePkg;
  typedef enum logic [1:0] {
    FP_HOLD = 2'd0,
    FP_UP   = 2'd1,
    FP_DOWN = 2'd2,
    FP_LOAD = 2'd3
  } fpOpE;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_DRAIN,
    SW_SAVE,
    SW_SWAP,
    SW_PRESENT
  } swStateE;

  // strobes from the switch sequencer to the frame datapath
  typedef struct packed {
    logic fpOpEn;   // pointer operations accepted
    logic savePc;   // store incoming PC chain into active frame
    logic loadFp;   // move pointer to switch target
  } ctxStrobeT;
endpackage

// File: rtl/ctxFrameCtrl.sv
module ctxFrameCtrl
  import ctxFramePkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_W    = $clog2(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               switchReq,
  input  logic [FRAME_W-1:0] switchTarget,
  input  logic               pipeEmpty,
  output ctxStrobeT          strobe,
  output logic [FRAME_W-1:0] swTarget,
  output logic               busy,
  output logic               haltIssue,
  output logic               resumeValid
);
  swStateE            state;
  logic               pend;
  logic [FRAME_W-1:0] pendTgt;
  logic               consume;
  logic               capture;

  // a held request is taken when the sequencer is idle or finishing
  assign consume = pend && (state == SW_IDLE || state == SW_PRESENT);
  assign capture = switchReq && (state != SW_IDLE || pend) && (!pend || consume);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SW_IDLE;
      pend     <= 1'b0;
      pendTgt  <= '0;
      swTarget <= '0;
    end else begin
      case (state)
        SW_IDLE: begin
          if (pend) begin
            state    <= SW_DRAIN;
            swTarget <= pendTgt;
          end else if (switchReq) begin
            state    <= SW_DRAIN;
            swTarget <= switchTarget;
          end
        end
        SW_DRAIN:   if (pipeEmpty) state <= SW_SAVE;
        SW_SAVE:    state <= SW_SWAP;
        SW_SWAP:    state <= SW_PRESENT;
        SW_PRESENT: begin
          if (pend) begin
            state    <= SW_DRAIN;
            swTarget <= pendTgt;
          end else begin
            state <= SW_IDLE;
          end
        end
        default:    state <= SW_IDLE;
      endcase
      if (capture) begin
        pend    <= 1'b1;
        pendTgt <= switchTarget;
      end else if (consume) begin
        pend <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.fpOpEn = (state == SW_IDLE);
    strobe.savePc = (state == SW_SAVE);
    strobe.loadFp = (state == SW_SWAP);
  end

  assign busy        = (state != SW_IDLE);
  assign haltIssue   = (state == SW_DRAIN);
  assign resumeValid = (state == SW_PRESENT);
endmodule

// File: rtl/ctxFrameData.sv
module ctxFrameData
  import ctxFramePkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_GLOBALS = 8,
  parameter int IDX_W       = 5,
  parameter int NUM_RD      = 2,
  parameter int FRAME_W     = $clog2(NUM_FRAMES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctxStrobeT                     strobe,
  input  logic [FRAME_W-1:0]            swTarget,
  input  logic [1:0]                    fpOp,
  input  logic [FRAME_W-1:0]            fpWrData,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rdIdx,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData,
  input  logic                          wrEn,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          statusWrEn,
  input  logic [DATA_W-1:0]             statusWrData,
  input  logic [DATA_W-1:0]             pcIn,
  input  logic [DATA_W-1:0]             npcIn,
  output logic [FRAME_W-1:0]            curFp,
  output logic [DATA_W-1:0]             statusRdData,
  output logic [DATA_W-1:0]             resumePc,
  output logic [DATA_W-1:0]             resumeNpc
);
  localparam int LOCAL_REGS = (1 << IDX_W) - NUM_GLOBALS;
  localparam int LOC_W      = $clog2(LOCAL_REGS);
  localparam int GLB_W      = $clog2(NUM_GLOBALS);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);
  localparam logic [IDX_W-1:0]   GLB_LIMIT  = IDX_W'(NUM_GLOBALS);

  logic [DATA_W-1:0]  globalReg [NUM_GLOBALS];
  logic [DATA_W-1:0]  frameReg  [NUM_FRAMES][LOCAL_REGS];
  logic [DATA_W-1:0]  pcSave    [NUM_FRAMES];
  logic [DATA_W-1:0]  npcSave   [NUM_FRAMES];
  logic [DATA_W-1:0]  statusReg [NUM_FRAMES];
  logic [FRAME_W-1:0] fp, fpNext;
  logic               wrGlobal;
  logic [IDX_W-1:0]   wrOff;

  // pointer update: forced switch wins, software ops only when idle
  always_comb begin
    fpNext = fp;
    if (strobe.loadFp) begin
      fpNext = swTarget;
    end else if (strobe.fpOpEn) begin
      case (fpOpE'(fpOp))
        FP_UP:   fpNext = (fp == LAST_FRAME) ? '0 : fp + 1'b1;
        FP_DOWN: fpNext = (fp == '0) ? LAST_FRAME : fp - 1'b1;
        FP_LOAD: fpNext = fpWrData;
        default: fpNext = fp;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) fp <= '0;
    else       fp <= fpNext;
  end

  assign wrGlobal = (wrIdx < GLB_LIMIT);
  assign wrOff    = wrIdx - GLB_LIMIT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GLOBALS; g++) globalReg[g] <= '0;
      for (int f = 0; f < NUM_FRAMES; f++) begin
        for (int r = 0; r < LOCAL_REGS; r++) frameReg[f][r] <= '0;
        pcSave[f]    <= '0;
        npcSave[f]   <= '0;
        statusReg[f] <= '0;
      end
    end else begin
      if (wrEn && wrGlobal)  globalReg[wrIdx[GLB_W-1:0]] <= wrData;
      if (wrEn && !wrGlobal) frameReg[fp][wrOff[LOC_W-1:0]] <= wrData;
      if (statusWrEn)        statusReg[fp] <= statusWrData;
      if (strobe.savePc) begin
        pcSave[fp]  <= pcIn;
        npcSave[fp] <= npcIn;
      end
    end
  end

  // one combinational read path per port
  for (genvar p = 0; p < NUM_RD; p++) begin : gRead
    logic [IDX_W-1:0] off;
    assign off = rdIdx[p] - GLB_LIMIT;
    always_comb begin
      if (rdIdx[p] < GLB_LIMIT) rdData[p] = globalReg[rdIdx[p][GLB_W-1:0]];
      else                      rdData[p] = frameReg[fp][off[LOC_W-1:0]];
    end
  end

  assign curFp        = fp;
  assign statusRdData = statusReg[fp];
  assign resumePc     = pcSave[fp];
  assign resumeNpc    = npcSave[fp];
endmodule

// File: rtl/ctxRegFile.sv
module ctxRegFile
  import ctxFramePkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_GLOBALS = 8,
  parameter int IDX_W       = 5,
  parameter int FRAME_W     = $clog2(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IDX_W-1:0]   rdIdxA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic [IDX_W-1:0]   rdIdxB,
  output logic [DATA_W-1:0]  rdDataB,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [1:0]         fpOp,
  input  logic [FRAME_W-1:0] fpWrData,
  output logic [FRAME_W-1:0] curFp,
  input  logic               statusWrEn,
  input  logic [DATA_W-1:0]  statusWrData,
  output logic [DATA_W-1:0]  statusRdData,
  input  logic [DATA_W-1:0]  pcIn,
  input  logic [DATA_W-1:0]  npcIn,
  input  logic               switchReq,
  input  logic [FRAME_W-1:0] switchTarget,
  input  logic               pipeEmpty,
  output logic               busy,
  output logic               haltIssue,
  output logic               resumeValid,
  output logic [DATA_W-1:0]  resumePc,
  output logic [DATA_W-1:0]  resumeNpc
);
  ctxStrobeT                strobe;
  logic [FRAME_W-1:0]       swTarget;
  logic [1:0][IDX_W-1:0]    rdIdx;
  logic [1:0][DATA_W-1:0]   rdData;

  assign rdIdx   = {rdIdxB, rdIdxA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  ctxFrameCtrl #(.NUM_FRAMES(NUM_FRAMES), .FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .switchReq(switchReq), .switchTarget(switchTarget),
    .pipeEmpty(pipeEmpty), .strobe(strobe), .swTarget(swTarget), .busy(busy),
    .haltIssue(haltIssue), .resumeValid(resumeValid)
  );

  ctxFrameData #(
    .DATA_W(DATA_W), .NUM_FRAMES(NUM_FRAMES), .NUM_GLOBALS(NUM_GLOBALS),
    .IDX_W(IDX_W), .NUM_RD(2), .FRAME_W(FRAME_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .swTarget(swTarget), .fpOp(fpOp),
    .fpWrData(fpWrData), .rdIdx(rdIdx), .rdData(rdData), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .statusWrEn(statusWrEn),
    .statusWrData(statusWrData), .pcIn(pcIn), .npcIn(npcIn), .curFp(curFp),
    .statusRdData(statusRdData), .resumePc(resumePc), .resumeNpc(resumeNpc)
  );
endmodule

// File: rtl/ctxRegFileChk.sv
module ctxRegFileChk #(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_W    = $clog2(NUM_FRAMES)
) (
  input logic               clk,
  input logic               rstN,
  input logic               switchReq,
  input logic               busy,
  input logic               haltIssue,
  input logic               resumeValid,
  input logic [1:0]         fpOp,
  input logic [FRAME_W-1:0] fpWrData,
  input logic [FRAME_W-1:0] curFp
);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

  // R4
  fp_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && fpOp == 2'd1) |=>
      curFp == (($past(curFp) == LAST_FRAME) ? '0 : $past(curFp) + 1'b1));

  // R4
  fp_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && fpOp == 2'd2) |=>
      curFp == (($past(curFp) == '0) ? LAST_FRAME : $past(curFp) - 1'b1));

  // R4
  fp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && fpOp == 2'd0) |=> $stable(curFp));

  // R5
  fp_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && fpOp == 2'd3) |=> curFp == $past(fpWrData));

  // R7
  switch_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (switchReq && !busy) |=> (busy && haltIssue));

  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltIssue |=> $stable(curFp));

  // R8
  present_inside_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |-> (busy && !haltIssue));

  // R8
  present_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |=> !resumeValid);
endmodule

bind ctxRegFile ctxRegFileChk #(.NUM_FRAMES(NUM_FRAMES), .FRAME_W(FRAME_W)) uChk (
  .clk(clk), .rstN(rstN), .switchReq(switchReq), .busy(busy),
  .haltIssue(haltIssue), .resumeValid(resumeValid), .fpOp(fpOp),
  .fpWrData(fpWrData), .curFp(curFp)
);

// File: tb/tb_ctxRegFile.sv
module tb_ctxRegFile;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  rdIdxA, rdIdxB, wrIdx;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic        wrEn;
  logic [1:0]  fpOp, fpWrData, curFp, switchTarget;
  logic        statusWrEn;
  logic [31:0] statusWrData, statusRdData, pcIn, npcIn, resumePc, resumeNpc;
  logic        switchReq, pipeEmpty, busy, haltIssue, resumeValid;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    string       req;
    logic [1:0]  fp;
    logic [31:0] pc;
    logic [31:0] npc;
  } expT;
  expT sbq[$];

  always #5 clk = ~clk;

  ctxRegFile dut (
    .clk(clk), .rstN(rstN), .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB),
    .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .fpOp(fpOp),
    .fpWrData(fpWrData), .curFp(curFp), .statusWrEn(statusWrEn),
    .statusWrData(statusWrData), .statusRdData(statusRdData), .pcIn(pcIn),
    .npcIn(npcIn), .switchReq(switchReq), .switchTarget(switchTarget),
    .pipeEmpty(pipeEmpty), .busy(busy), .haltIssue(haltIssue),
    .resumeValid(resumeValid), .resumePc(resumePc), .resumeNpc(resumeNpc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] idx, input logic [31:0] val);
    wrEn = 1'b1; wrIdx = idx; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [4:0] idx, input logic [31:0] exp);
    rdIdxA = idx; rdIdxB = idx;
    #1;
    check(req, rdDataA, exp);
    check(req, rdDataB, exp);
  endtask

  task automatic fpCmd(input logic [1:0] op, input logic [1:0] val);
    fpOp = op; fpWrData = val;
    @(negedge clk);
    fpOp = 2'd0;
  endtask

  task automatic pushExp(input string req, input logic [1:0] fp,
                         input logic [31:0] pc, input logic [31:0] npc);
    expT e;
    e.req = req; e.fp = fp; e.pc = pc; e.npc = npc;
    sbq.push_back(e);
  endtask

  // monitor: each PC-chain presentation is compared with the next queued item
  always @(negedge clk) begin
    if (rstN && resumeValid) begin
      if (sbq.size() == 0) begin
        check("R8 unexpected presentation", 32'd1, 32'd0);
      end else begin
        expT e;
        e = sbq.pop_front();
        check({e.req, " fp"},  {30'd0, curFp}, {30'd0, e.fp});
        check({e.req, " pc"},  resumePc, e.pc);
        check({e.req, " npc"}, resumeNpc, e.npc);
      end
    end
  end

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int cnt;
    rstN = 1'b0; wrEn = 1'b0; wrIdx = '0; wrData = '0; rdIdxA = '0; rdIdxB = '0;
    fpOp = '0; fpWrData = '0; statusWrEn = 1'b0; statusWrData = '0;
    pcIn = '0; npcIn = '0; switchReq = 1'b0; switchTarget = '0; pipeEmpty = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 fp",     {30'd0, curFp}, 32'd0);
    check("R1 busy",   {29'd0, busy, haltIssue, resumeValid}, 32'd0);
    check("R1 status", statusRdData, 32'd0);
    check("R1 pc",     resumePc, 32'd0);
    readCheck("R1 reg", 5'd12, 32'd0);

    // R2 shared and R3 local registers
    writeReg(5'd3,  32'hAAAA_0003);
    writeReg(5'd10, 32'hB0B0_0010);
    fpCmd(2'd1, 2'd0);
    check("R4 up", {30'd0, curFp}, 32'd1);
    readCheck("R2 shared from frame1", 5'd3, 32'hAAAA_0003);
    readCheck("R3 local isolated",     5'd10, 32'd0);
    writeReg(5'd10, 32'hC1C1_0010);
    fpCmd(2'd2, 2'd0);
    check("R4 down", {30'd0, curFp}, 32'd0);
    readCheck("R3 local kept", 5'd10, 32'hB0B0_0010);

    // R4 wrap both ways, hold
    fpCmd(2'd2, 2'd0);
    check("R4 down wrap", {30'd0, curFp}, 32'd3);
    fpCmd(2'd1, 2'd0);
    check("R4 up wrap", {30'd0, curFp}, 32'd0);
    fpCmd(2'd0, 2'd3);
    check("R4 hold", {30'd0, curFp}, 32'd0);

    // R5 load, R6 status per frame
    fpCmd(2'd3, 2'd2);
    check("R5 load", {30'd0, curFp}, 32'd2);
    statusWrEn = 1'b1; statusWrData = 32'h5A5A_1234;
    @(negedge clk);
    statusWrEn = 1'b0;
    check("R6 status write", statusRdData, 32'h5A5A_1234);
    fpCmd(2'd3, 2'd0);
    check("R6 status other frame", statusRdData, 32'd0);
    fpCmd(2'd3, 2'd2);
    check("R6 status kept", statusRdData, 32'h5A5A_1234);
    fpCmd(2'd3, 2'd0);

    // R7 drain wait, R9 ignored pointer op
    pipeEmpty = 1'b0;
    pcIn = 32'h0000_0100; npcIn = 32'h0000_0104;
    switchReq = 1'b1; switchTarget = 2'd1;
    @(negedge clk);
    switchReq = 1'b0;
    check("R7 busy", {30'd0, busy, haltIssue}, 32'd3);
    fpOp = 2'd1;
    @(negedge clk);
    fpOp = 2'd0;
    check("R9 op ignored", {30'd0, curFp}, 32'd0);
    @(negedge clk);
    check("R7 fp held in drain", {30'd0, curFp}, 32'd0);
    pushExp("R8 switch to frame1", 2'd1, 32'd0, 32'd0);
    pipeEmpty = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 busy cleared", {31'd0, busy}, 32'd0);

    // R11 busy window, R8 saved chain returns
    pcIn = 32'h0000_0200; npcIn = 32'h0000_0204;
    pushExp("R8 back to frame0", 2'd0, 32'h0000_0100, 32'h0000_0104);
    switchReq = 1'b1; switchTarget = 2'd0;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      switchReq = 1'b0;
      cnt += int'(busy);
    end
    check("R11 busy cycles", cnt, 32'd4);
    readCheck("R3 local after switch",  5'd10, 32'hB0B0_0010);
    readCheck("R2 shared after switch", 5'd3,  32'hAAAA_0003);

    // R10 held request
    pcIn = 32'h0000_0300; npcIn = 32'h0000_0304;
    pushExp("R10 first switch", 2'd2, 32'd0, 32'd0);
    pushExp("R10 held switch",  2'd1, 32'h0000_0200, 32'h0000_0204);
    switchReq = 1'b1; switchTarget = 2'd2;
    @(negedge clk);
    switchTarget = 2'd1;
    @(negedge clk);
    switchReq = 1'b0;
    repeat (12) @(negedge clk);
    check("R10 final fp", {30'd0, curFp}, 32'd1);
    check("R10 idle", {31'd0, busy}, 32'd0);
    check("R8 queue drained", sbq.size(), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule